// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-clock static RAM with a pipelined read path and short bursts. Every pin is captured in an input register on the rising edge. In the next cycle the captured command is decoded, and a write is committed to the array or the addressed word is loaded into an output register. Read data is therefore presented after the second rising edge that follows the cycle in which the address was driven. The word is split into byte lanes of nine bits each: eight data bits and one parity-width extension bit. Lanes are written under per-lane strobes, and a global write forces all lanes at once.

A burst is opened by one of two active-low start strobes. The CPU-side strobe always opens a read. The controller-side strobe lets the write controls of the same cycle take effect. The strobe loads the full address, and a 2-bit counter then walks the two low address bits under an advance input. The walk is either linear or interleaved, chosen by an order pin, or fixed by a parameter when the pin is not used. Three chip enables of mixed polarity qualify every strobe. A strobe that arrives while any enable is inactive deselects the part and ends the burst.

Read data leaves through a valid-qualified output. There is no ready input, because the pipeline never stalls: a consumer must take each word in the cycle in which `rvalid_o` is high. Data is not held for back-pressure.

Top module: `burst_sram`

## Requirements
- R1: A read whose inputs are captured at rising edge E drives `rvalid_o` high and presents the word on `rdata_o` after edge E+1. Before edge E+1, `rvalid_o` still reflects the earlier cycle.
- R2: Either start strobe, asserted while `en0_n`=0, `en1`=1 and `en2_n`=0, loads the full address and sets the burst count to 0. The first access of the burst uses exactly that address.
- R3: With `order_ilv`=0, the k-th access of a burst uses low bits (start+k) mod 4. The upper address bits never change, so a burst wraps within its four-word group.
- R4: With `order_ilv`=1, the k-th access uses low bits start XOR k.
- R5: In a cycle with no strobe during an open burst, `adv_n`=0 steps the count by one and `adv_n`=1 repeats the current address.
- R6: A burst opened by `start_cpu_n` is a read, whatever the write controls are in that cycle.
- R7: When `wr_all_n`=1 on a controller-strobe or continuation cycle, the cycle writes only if `wr_byte_n`=0. In that case it writes exactly the lanes whose `lane_sel_n` bit is 0; lane i is data bits [9i+8:9i]. With `wr_byte_n`=1, or no lane selected, the cycle is a read.
- R8: `wr_all_n`=0 on a controller-strobe or continuation cycle writes all four lanes, whatever `wr_byte_n` and `lane_sel_n` are.
- R9: A strobe with any chip enable inactive deselects the part. It writes nothing, `rvalid_o` is low after the following edge, and later strobe-free cycles do nothing until a new start.
- R10: `rvalid_o` is low after reset. After each edge it is high only for a read, and low for writes, deselects and idle cycles.
- R11: With parameter `ORDER_PIN`=0, the burst order is fixed by `TIE_ILV` (default 1, interleaved) and `order_ilv` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, loaded on a burst start |
| wdata_i | input | LANES*LANE_W | Write data, lane i in bits [9i+8:9i] |
| start_cpu_n | input | 1 | Active-low burst start, read only |
| start_ctl_n | input | 1 | Active-low burst start, write controls honoured |
| adv_n | input | 1 | Active-low burst step request |
| en0_n | input | 1 | Active-low chip enable |
| en1 | input | 1 | Active-high chip enable |
| en2_n | input | 1 | Active-low chip enable |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_byte_n | input | 1 | Active-low enable for lane writes |
| lane_sel_n | input | LANES | Active-low per-lane write select |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | LANES*LANE_W | Registered read word |
| rvalid_o | output | 1 | High in the cycle in which rdata_o holds a read result |

## Verification
Write bursts opened at four-word-aligned addresses fill a region. Reads starting at each low-bit offset under both orders then separate linear wrap from interleaved XOR, and stepping from holding. Single-lane and two-lane writes, including on a continuation cycle, are set against full-width global writes with the lane controls idle. This shows whether the enable gating and the global override act on the right lanes. CPU-strobe cycles with write controls active, and deselects on each of the three enables, are followed by reads of the same word, which expose any write that should have been suppressed. A second instance, with the order pin unused, runs on the same stimulus, and a long mixed sequence of random strobes, steps, orders and lane masks checks every cycle's valid flag and data.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } bsram_op_e;

  // Low address bits of the k-th burst access.
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] seed,
    input logic [BURST_W-1:0] step,
    input logic               ilv
  );
    return ilv ? (seed ^ step) : (seed + step);
  endfunction

endpackage

// File: rtl/bsram_in_stage.sv
module bsram_in_stage #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_cpu_n,
  input  logic              start_ctl_n,
  input  logic              adv_n,
  input  logic              en0_n,
  input  logic              en1,
  input  logic              en2_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              cpu_n_q,
  output logic              ctl_n_q,
  output logic              adv_n_q,
  output logic              en0_n_q,
  output logic              en1_q,
  output logic              en2_n_q,
  output logic              all_n_q,
  output logic              byte_n_q,
  output logic [LANES-1:0]  sel_n_q,
  output logic              ilv_q
);

  // Every pin passes through this stage; reset values are the inactive levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      cpu_n_q  <= 1'b1;
      ctl_n_q  <= 1'b1;
      adv_n_q  <= 1'b1;
      en0_n_q  <= 1'b1;
      en1_q    <= 1'b0;
      en2_n_q  <= 1'b1;
      all_n_q  <= 1'b1;
      byte_n_q <= 1'b1;
      sel_n_q  <= '1;
      ilv_q    <= 1'b1;
    end else begin
      addr_q   <= addr_i;
      wdata_q  <= wdata_i;
      cpu_n_q  <= start_cpu_n;
      ctl_n_q  <= start_ctl_n;
      adv_n_q  <= adv_n;
      en0_n_q  <= en0_n;
      en1_q    <= en1;
      en2_n_q  <= en2_n;
      all_n_q  <= wr_all_n;
      byte_n_q <= wr_byte_n;
      sel_n_q  <= lane_sel_n;
      ilv_q    <= order_ilv;
    end
  end

endmodule

// File: rtl/bsram_burst_ctrl.sv
module bsram_burst_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter bit ORDER_PIN = 1'b1,
  parameter bit TIE_ILV   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              cpu_n_q,
  input  logic              ctl_n_q,
  input  logic              adv_n_q,
  input  logic              en0_n_q,
  input  logic              en1_q,
  input  logic              en2_n_q,
  input  logic              all_n_q,
  input  logic              byte_n_q,
  input  logic [LANES-1:0]  sel_n_q,
  input  logic              ilv_q,
  output bsram_op_e         op_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic [BURST_W-1:0] cnt_o,
  output logic              start_o,
  output logic              step_o,
  output logic              hold_o
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic               open_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;

  logic               chip_on, strobe, start, desel, cont, may_write, ilv;
  logic [LANES-1:0]   lanes_req;
  logic [ADDR_W-1:0]  base_nx;
  logic [BURST_W-1:0] cnt_nx;

  // Order selection: either the registered pin or a fixed tie level.
  generate
    if (ORDER_PIN) begin : g_pin_order
      assign ilv = ilv_q;
    end else begin : g_tied_order
      assign ilv = TIE_ILV;
    end
  endgenerate

  always_comb begin
    chip_on   = !en0_n_q && en1_q && !en2_n_q;
    strobe    = !cpu_n_q || !ctl_n_q;
    start     = strobe && chip_on;
    desel     = strobe && !chip_on;
    cont      = !strobe && open_q;
    lanes_req = !all_n_q ? {LANES{1'b1}} : (!byte_n_q ? ~sel_n_q : {LANES{1'b0}});
    // CPU strobe forces a read; controller strobe and continuations honour writes
    may_write = start ? cpu_n_q : cont;

    base_nx = start ? addr_q : base_q;
    if (start)
      cnt_nx = '0;
    else if (cont && !adv_n_q)
      cnt_nx = cnt_q + 1'b1;
    else
      cnt_nx = cnt_q;

    eff_addr_o = {base_nx[ADDR_W-1 -: HI_W], burst_low(base_nx[BURST_W-1:0], cnt_nx, ilv)};

    if (desel)
      op_o = OP_DESEL;
    else if (start || cont)
      op_o = (may_write && (|lanes_req)) ? OP_WRITE : OP_READ;
    else
      op_o = OP_IDLE;

    lane_we_o = (op_o == OP_WRITE) ? lanes_req : {LANES{1'b0}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (start)      open_q <= 1'b1;
      else if (desel) open_q <= 1'b0;
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
    end
  end

  assign cnt_o   = cnt_q;
  assign start_o = start;
  assign step_o  = cont && !adv_n_q;
  assign hold_o  = cont && adv_n_q;

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  // One storage column per lane so lane writes need no read-modify-write.
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] col [DEPTH];

      always_ff @(posedge clk) begin
        if (lane_we[g])
          col[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rd_word[g*LANE_W +: LANE_W] = col[addr];
    end
  endgenerate

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en)
        rdata_o <= rd_word;
    end
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter bit ORDER_PIN = 1'b1,
  parameter bit TIE_ILV   = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    start_cpu_n,
  input  logic                    start_ctl_n,
  input  logic                    adv_n,
  input  logic                    en0_n,
  input  logic                    en1,
  input  logic                    en2_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    order_ilv,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0]  addr_q, eff_addr;
  logic [DATA_W-1:0]  wdata_q, rd_word;
  logic               cpu_n_q, ctl_n_q, adv_n_q, en0_n_q, en1_q, en2_n_q;
  logic               all_n_q, byte_n_q, ilv_q;
  logic [LANES-1:0]   sel_n_q, lane_we;
  bsram_op_e          op_w;
  logic [BURST_W-1:0] cnt_w;
  logic               start_w, step_w, hold_w;

  bsram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .adv_n(adv_n),
    .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .order_ilv(order_ilv),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .cpu_n_q(cpu_n_q), .ctl_n_q(ctl_n_q), .adv_n_q(adv_n_q),
    .en0_n_q(en0_n_q), .en1_q(en1_q), .en2_n_q(en2_n_q),
    .all_n_q(all_n_q), .byte_n_q(byte_n_q), .sel_n_q(sel_n_q),
    .ilv_q(ilv_q)
  );

  bsram_burst_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .ORDER_PIN(ORDER_PIN), .TIE_ILV(TIE_ILV)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .addr_q(addr_q), .cpu_n_q(cpu_n_q), .ctl_n_q(ctl_n_q), .adv_n_q(adv_n_q),
    .en0_n_q(en0_n_q), .en1_q(en1_q), .en2_n_q(en2_n_q),
    .all_n_q(all_n_q), .byte_n_q(byte_n_q), .sel_n_q(sel_n_q), .ilv_q(ilv_q),
    .op_o(op_w), .eff_addr_o(eff_addr), .lane_we_o(lane_we), .cnt_o(cnt_w),
    .start_o(start_w), .step_o(step_w), .hold_o(hold_w)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .addr(eff_addr), .lane_we(lane_we), .wdata(wdata_q), .rd_word(rd_word)
  );

  bsram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .rd_en(op_w == OP_READ), .rd_word(rd_word),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import bsram_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         op_i,
  input logic [BURST_W-1:0] cnt_i,
  input logic               start_i,
  input logic               step_i,
  input logic               hold_i,
  input logic               rvalid_i
);

  a_r10_read_raises_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_READ) |=> rvalid_i);

  a_r10_write_lowers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_WRITE) |=> !rvalid_i);

  a_r9_deselect_lowers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DESEL) |=> !rvalid_i);

  a_r2_start_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_i == '0));

  a_r5_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (cnt_i == BURST_W'($past(cnt_i) + 1'b1)));

  a_r5_hold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(cnt_i));

endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_w), .cnt_i(cnt_w),
  .start_i(start_w), .step_i(step_w), .hold_i(hold_w), .rvalid_i(rvalid_o)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [7:0]  r_addr;
  logic [35:0] r_wd;
  logic        r_ps, r_cs, r_adv, r_e0n, r_e1, r_e2n, r_gw, r_bwe, r_mode;
  logic [3:0]  r_bw;
  logic [35:0] rdata_a, rdata_b;
  logic        rvalid_a, rvalid_b;

  burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addr_i(r_addr), .wdata_i(r_wd),
    .start_cpu_n(r_ps), .start_ctl_n(r_cs), .adv_n(r_adv),
    .en0_n(r_e0n), .en1(r_e1), .en2_n(r_e2n),
    .wr_all_n(r_gw), .wr_byte_n(r_bwe), .lane_sel_n(r_bw), .order_ilv(r_mode),
    .rdata_o(rdata_a), .rvalid_o(rvalid_a)
  );

  // R11: order pin unused, tied interleaved
  burst_sram #(.ORDER_PIN(1'b0), .TIE_ILV(1'b1)) dut_tie (
    .clk(clk), .rst_n(rst_n), .addr_i(r_addr), .wdata_i(r_wd),
    .start_cpu_n(r_ps), .start_ctl_n(r_cs), .adv_n(r_adv),
    .en0_n(r_e0n), .en1(r_e1), .en2_n(r_e2n),
    .wr_all_n(r_gw), .wr_byte_n(r_bwe), .lane_sel_n(r_bw), .order_ilv(r_mode),
    .rdata_o(rdata_b), .rvalid_o(rvalid_b)
  );

  typedef struct {
    int          due;
    logic        v;
    logic [35:0] d;
    logic        vb;
    logic [35:0] db;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        mon_e;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          ncyc  = 0;

  // reference state
  logic        m_open = 1'b0;
  logic [7:0]  m_base = '0;
  logic [1:0]  m_cnt  = '0;
  logic [35:0] ma [256];
  logic [35:0] mb [256];

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic check(input string tag, input string what,
                       input logic [35:0] got, input logic [35:0] want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  function automatic logic [35:0] pat(input logic [7:0] x);
    return {x, 4'h9, x ^ 8'h5A, 8'h3C, ~x};
  endfunction

  task automatic set_idle();
    r_ps = 1'b1; r_cs = 1'b1; r_adv = 1'b1;
    r_e0n = 1'b0; r_e1 = 1'b1; r_e2n = 1'b1 ^ 1'b1;
    r_gw = 1'b1; r_bwe = 1'b1; r_bw = 4'hF; r_wd = '0;
  endtask

  // Driver: one clock, then the reference decides the expected result.
  task automatic step(input string tag);
    exp_t        e;
    logic        ce, strb, wr;
    logic [3:0]  ln;
    logic [7:0]  ea, eb;
    @(posedge clk); #1;
    ce   = !r_e0n && r_e1 && !r_e2n;
    strb = !r_ps || !r_cs;
    ln   = !r_gw ? 4'hF : (!r_bwe ? ~r_bw : 4'h0);
    e.due = ncyc + 1; e.v = 1'b0; e.d = '0; e.vb = 1'b0; e.db = '0; e.tag = tag;
    if (strb && !ce) begin
      m_open = 1'b0;
    end else if (strb || m_open) begin
      if (strb) begin
        m_base = r_addr; m_cnt = 2'd0; m_open = 1'b1;
        wr = r_ps && (ln != 4'h0);
      end else begin
        if (!r_adv) m_cnt = m_cnt + 2'd1;
        wr = (ln != 4'h0);
      end
      ea = {m_base[7:2], r_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
      eb = {m_base[7:2], m_base[1:0] ^ m_cnt};
      if (wr) begin
        for (int i = 0; i < 4; i++) begin
          if (ln[i]) begin
            ma[ea][i*9 +: 9] = r_wd[i*9 +: 9];
            mb[eb][i*9 +: 9] = r_wd[i*9 +: 9];
          end
        end
      end else begin
        e.v = 1'b1; e.d = ma[ea]; e.vb = 1'b1; e.db = mb[eb];
      end
    end
    sb.push_back(e);
    set_idle();
  endtask

  task automatic go_ctl(input string tag, input logic [7:0] a, input logic gw,
                        input logic bwe, input logic [3:0] bw, input logic [35:0] d);
    r_cs = 1'b0; r_addr = a; r_gw = gw; r_bwe = bwe; r_bw = bw; r_wd = d;
    step(tag);
  endtask

  task automatic go_cpu(input string tag, input logic [7:0] a);
    r_ps = 1'b0; r_addr = a;
    step(tag);
  endtask

  task automatic go_cont(input string tag, input logic adv, input logic gw,
                         input logic bwe, input logic [3:0] bw, input logic [35:0] d);
    r_adv = adv; r_gw = gw; r_bwe = bwe; r_bw = bw; r_wd = d;
    step(tag);
  endtask

  // Monitor: compares each result in the cycle it is due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= ncyc) begin
      mon_e = sb.pop_front();
      check(mon_e.tag, "rvalid", {35'd0, rvalid_a}, {35'd0, mon_e.v});
      if (mon_e.v) check(mon_e.tag, "rdata", rdata_a, mon_e.d);
      check("R11", "tie rvalid", {35'd0, rvalid_b}, {35'd0, mon_e.vb});
      if (mon_e.vb) check("R11", "tie rdata", rdata_b, mon_e.db);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rn;
    rst_n = 1'b0; r_mode = 1'b0; r_addr = '0;
    set_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "reset rvalid", {35'd0, rvalid_a}, 36'd0);
    check("R10", "reset tie rvalid", {35'd0, rvalid_b}, 36'd0);
    rst_n = 1'b1;
    step("R10");

    // R8: fill 0x10..0x2F with global-write bursts from aligned starts
    for (int b = 0; b < 8; b++) begin
      go_ctl("R8", 8'(8'h10 + 4*b), 1'b0, 1'b1, 4'hF, pat(8'(8'h10 + 4*b)));
      for (int k = 1; k < 4; k++)
        go_cont("R8", 1'b0, 1'b0, 1'b1, 4'hF, pat(8'(8'h10 + 4*b + k)));
    end

    // R2 / R3: linear read burst, then a wrapping one
    go_cpu("R2", 8'h10);
    for (int k = 0; k < 3; k++) go_cont("R3", 1'b0, 1'b1, 1'b1, 4'hF, '0);
    go_cpu("R3", 8'h13);
    for (int k = 0; k < 3; k++) go_cont("R3", 1'b0, 1'b1, 1'b1, 4'hF, '0);

    // R5: holds and steps
    go_cpu("R5", 8'h15);
    go_cont("R5", 1'b1, 1'b1, 1'b1, 4'hF, '0);
    go_cont("R5", 1'b1, 1'b1, 1'b1, 4'hF, '0);
    go_cont("R5", 1'b0, 1'b1, 1'b1, 4'hF, '0);
    go_cont("R5", 1'b0, 1'b1, 1'b1, 4'hF, '0);

    // R4: interleaved order
    r_mode = 1'b1;
    go_cpu("R4", 8'h16);
    for (int k = 0; k < 3; k++) go_cont("R4", 1'b0, 1'b1, 1'b1, 4'hF, '0);
    go_cpu("R4", 8'h1B);
    for (int k = 0; k < 3; k++) go_cont("R4", 1'b0, 1'b1, 1'b1, 4'hF, '0);
    r_mode = 1'b0;

    // R1: isolated read from idle
    step("R1");
    go_cpu("R1", 8'h21);
    step("R1");
    step("R1");

    // R7: lane writes on start and on a continuation
    go_ctl("R7", 8'h24, 1'b1, 1'b0, 4'b1010, 36'hF_FFFF_FFFF);
    go_cont("R7", 1'b0, 1'b1, 1'b0, 4'b0111, 36'h0_0000_0000);
    go_cpu("R7", 8'h24);
    go_cont("R7", 1'b0, 1'b1, 1'b1, 4'hF, '0);
    // R7: lane selects without enable read instead of write
    go_ctl("R7", 8'h28, 1'b1, 1'b1, 4'h0, 36'h1_2345_6789);
    go_cpu("R7", 8'h28);

    // R6: CPU strobe ignores an active global write
    r_gw = 1'b0; r_bwe = 1'b0; r_bw = 4'h0; r_wd = 36'hA_AAAA_AAAA;
    go_cpu("R6", 8'h29);
    step("R6");
    go_cpu("R6", 8'h29);

    // R8: global write overrides idle lane controls
    go_ctl("R8", 8'h2C, 1'b0, 1'b1, 4'hF, 36'h5_5A5A_0F0F);
    go_cpu("R8", 8'h2C);

    // R9: each enable deselects; nothing written, burst closed
    for (int j = 0; j < 3; j++) begin
      go_cpu("R9", 8'h2D);
      if (j == 0) r_e0n = 1'b1;
      if (j == 1) r_e1 = 1'b0;
      if (j == 2) r_e2n = 1'b1;
      r_cs = 1'b0; r_addr = 8'h2C; r_gw = 1'b0; r_wd = 36'h0_DEAD_BEEF;
      step("R9");
      go_cont("R9", 1'b0, 1'b0, 1'b1, 4'hF, 36'h0_0BAD_F00D);
      go_cpu("R9", 8'h2C);
    end

    // R10: mixed traffic in the filled region
    for (int n = 0; n < 400; n++) begin
      rn = $urandom();
      r_mode = rn[0];
      r_ps   = !(rn[3:1] == 3'd0);
      r_cs   = !(rn[3:1] == 3'd1);
      r_adv  = rn[4];
      r_gw   = !(rn[7:5] == 3'd0);
      r_bwe  = !(rn[7:5] == 3'd1 || rn[7:5] == 3'd2);
      r_bw   = rn[11:8];
      r_addr = 8'(8'h10 + rn[16:12]);
      r_wd   = {rn[31:20], rn[23:0]};
      if (rn[19:17] == 3'd0) r_e1 = 1'b0;
      step("R10");
    end

    for (int n = 0; n < 4; n++) step("R10");
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule